// File: doc/BRIEF.md
# Doorbell Interrupt Register Pair

This block holds two byte-wide registers on a simple I/O bus. Software on either side of a bridge uses them to raise interrupts toward a local processor. The status byte holds four flags and one enable per flag. Two of the flags are location-monitor flags and two are signal flags. Software can read and write the enables, but it can only read the flags.

The flags change only through the companion control byte. That byte carries a one-shot set strobe and a one-shot clear strobe for each flag. A hardware location-monitor hit also sets the matching location-monitor flag. Each flag ANDed with its enable drives one level interrupt output.

Reads are combinational from the address. Writes take effect at the next clock edge.

Top module: `dbell_irq_regs`

## Requirements
- R1: After a synchronous reset, all enables and flags are 0, every irq bit is 0, and a read of the status address returns 0x00.
- R2: A write to the status address (0x1001) loads wdata[7:4] into the enables. The flags are unchanged, whatever wdata[3:0] holds.
- R3: A write to the control address (0x1000) sets flag k when wdata[k+4] is 1, and clears flag k when wdata[k] is 1. Flag index 0 is LM0, 1 is LM1, 2 is SIG0 and 3 is SIG1. A strobe bit written as 0 leaves its flag unchanged.
- R4: When the set and clear strobes for the same flag are both 1 in one control write, the flag ends up 1.
- R5: While lm_hit[j] is 1 at a clock edge, flag j (LM0 for j=0, LM1 for j=1) becomes 1. This holds even if the same cycle's control write clears that flag.
- R6: A read of the control address always returns 0x00.
- R7: irq[k] is 1 exactly while enable k and flag k are both 1. irq is a level signal with the same bit order as the flags, and it follows the registers with no added delay.
- R8: A write to any address other than 0x1000 or 0x1001 changes no register.
- R9: A read of the status address returns the enables in bits 7:4 and the flags in bits 3:0, both in the flag index order of R3. A read of any other address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | I/O address for reads and writes |
| wr_en | input | 1 | Write strobe for the current address |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte, combinational from addr |
| lm_hit | input | 2 | Hardware location-monitor hits, one per LM flag |
| irq | output | 4 | Level interrupts, flag&enable, order LM0, LM1, SIG0, SIG1 |

## Verification
The bench writes the status byte with junk in its low nibble. A design that lets the status write reach the flags would show changed flags on readback. It also drives set and clear for the same flag together, and a hardware hit together with a clear. Here a design with the wrong priority leaves the flag at 0. It reads the control address after strobe writes, which catches strobes that are stored instead of self-clearing, and it writes to nearby addresses to catch sloppy decoding. A long pseudo-random phase compares every cycle against a behavioural model, so a swapped bit index or a missing enable gate shows up as a mismatch on rdata or irq.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

    localparam int NFLAG  = 4;
    localparam int BYTE_W = 2 * NFLAG;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_STAT = 2'd2
    } sel_e;

    typedef struct packed {
        logic [NFLAG-1:0] en;
        logic [NFLAG-1:0] fl;
    } stat_t;

    typedef struct packed {
        logic [NFLAG-1:0] set;
        logic [NFLAG-1:0] clr;
    } ctrl_t;

    function automatic sel_e decode_addr(
        input logic [15:0] a,
        input logic [15:0] stat_ofs,
        input logic [15:0] ctrl_ofs
    );
        if (a == stat_ofs)      return SEL_STAT;
        else if (a == ctrl_ofs) return SEL_CTRL;
        else                    return SEL_NONE;
    endfunction

endpackage

// File: rtl/dbell_flag.sv
module dbell_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (rst)        q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end
endmodule

// File: rtl/dbell_rdmux.sv
module dbell_rdmux
    import dbell_pkg::*;
(
    input  sel_e               sel_i,
    input  stat_t              stat_i,
    output logic [BYTE_W-1:0]  rdata_o
);
    always_comb begin
        unique case (sel_i)
            SEL_STAT: rdata_o = stat_i;
            default:  rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/dbell_irq_regs.sv
module dbell_irq_regs
    import dbell_pkg::*;
#(
    parameter logic [15:0] STAT_OFS = 16'h1001,
    parameter logic [15:0] CTRL_OFS = 16'h1000,
    parameter int          N_LM     = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [15:0]        addr,
    input  logic               wr_en,
    input  logic [7:0]         wdata,
    output logic [7:0]         rdata,
    input  logic [N_LM-1:0]    lm_hit,
    output logic [NFLAG-1:0]   irq
);
    sel_e             sel;
    logic             wr_ctrl;
    logic             wr_stat;
    ctrl_t            cw;
    logic [NFLAG-1:0] hit_vec;
    logic [NFLAG-1:0] fl;
    logic [NFLAG-1:0] en;
    stat_t            stat;

    assign sel     = decode_addr(addr, STAT_OFS, CTRL_OFS);
    assign wr_ctrl = wr_en && (sel == SEL_CTRL);
    assign wr_stat = wr_en && (sel == SEL_STAT);
    assign cw      = wdata;
    assign hit_vec = NFLAG'(lm_hit);

    // enable bits: only the upper nibble of a status write lands
    always_ff @(posedge clk) begin
        if (rst)          en <= '0;
        else if (wr_stat) en <= wdata[7:4];
    end

    for (genvar k = 0; k < NFLAG; k++) begin : g_flag
        logic set_k;
        logic clr_k;
        assign set_k = (wr_ctrl && cw.set[k]) || hit_vec[k];
        assign clr_k = wr_ctrl && cw.clr[k];

        dbell_flag u_flag (
            .clk   (clk),
            .rst   (rst),
            .set_i (set_k),
            .clr_i (clr_k),
            .q_o   (fl[k])
        );

        AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
            (wr_ctrl && cw.set[k] && cw.clr[k]) |=> fl[k]);  // R4
        AST_CLR_ONLY: assert property (@(posedge clk) disable iff (rst)
            (wr_ctrl && cw.clr[k] && !cw.set[k] && !hit_vec[k]) |=> !fl[k]);  // R3
        AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
            (!wr_ctrl && !hit_vec[k]) |=> $stable(fl[k]));  // R2
        if (k < N_LM) begin : g_hit
            AST_HIT_SETS: assert property (@(posedge clk) disable iff (rst)
                lm_hit[k] |=> fl[k]);  // R5
        end
    end

    assign stat.en = en;
    assign stat.fl = fl;
    assign irq     = en & fl;

    dbell_rdmux u_rdmux (
        .sel_i   (sel),
        .stat_i  (stat),
        .rdata_o (rdata)
    );

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_stat |=> $stable(en));  // R8
    AST_CTRL_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_CTRL) |-> (rdata == 8'h00));  // R6
    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_STAT) |-> (irq == (rdata[7:4] & rdata[3:0])));  // R7
    AST_RESET_CLEAN: assert property (@(posedge clk)
        $past(rst) |-> (irq == '0));  // R1
endmodule

// File: tb/sim_dbell_irq_regs.sv
module sim_dbell_irq_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = 16'h0;
    logic        wr_en = 1'b0;
    logic [7:0]  wdata = 8'h0;
    logic [1:0]  lm_hit = 2'b0;
    logic [7:0]  rdata;
    logic [3:0]  irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";
    logic [3:0] en_m = 4'h0;
    logic [3:0] fl_m = 4'h0;

    always #2ns clk = ~clk;

    dbell_irq_regs u0 (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .lm_hit(lm_hit), .irq(irq)
    );

    // behavioural reference model
    always @(posedge clk) begin
        if (rst) begin
            en_m = 4'h0;
            fl_m = 4'h0;
        end else begin
            if (wr_en && addr == 16'h1001) en_m = wdata[7:4];
            for (int k = 0; k < 4; k++) begin
                bit s, c;
                s = (wr_en && addr == 16'h1000 && wdata[k+4]) || (k < 2 && lm_hit[k]);
                c = wr_en && addr == 16'h1000 && wdata[k];
                if (s) fl_m[k] = 1'b1;
                else if (c) fl_m[k] = 1'b0;
            end
        end
    end

    function automatic logic [7:0] exp_rd();
        if (addr == 16'h1001) return {en_m, fl_m};
        return 8'h00;
    endfunction

    // compare every cycle, 1 ns after the edge
    always @(posedge clk) begin
        #1ns;
        checks++;
        if (rdata !== exp_rd() || irq !== (en_m & fl_m)) begin
            errors++;
            $display("FAIL %s: rdata=%h irq=%h expected rdata=%h irq=%h",
                     cur_req, rdata, irq, exp_rd(), en_m & fl_m);
        end
    end

    task automatic step(input logic [15:0] a, input logic w,
                        input logic [7:0] d, input logic [1:0] h);
        @(negedge clk);
        addr = a; wr_en = w; wdata = d; lm_hit = h;
        @(posedge clk);
    endtask

    task automatic expect_rd(input string req, input logic [15:0] a,
                             input logic [7:0] e);
        @(negedge clk);
        addr = a; wr_en = 1'b0; lm_hit = 2'b0;
        #0.5ns;
        checks++;
        if (rdata !== e) begin
            errors++;
            $display("FAIL %s: rdata=%h expected %h", req, rdata, e);
        end
    endtask

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        cur_req = "R1";
        expect_rd("R1", 16'h1001, 8'h00);

        cur_req = "R2";
        step(16'h1001, 1, 8'hAF, 0);              // enables=1010, junk low nibble
        expect_rd("R2", 16'h1001, 8'hA0);

        cur_req = "R3";
        step(16'h1000, 1, 8'hF0, 0);              // set all flags
        expect_rd("R3", 16'h1001, 8'hAF);
        step(16'h1000, 1, 8'h05, 0);              // clear SIG0, LM0
        expect_rd("R3", 16'h1001, 8'hAA);
        step(16'h1000, 1, 8'h00, 0);              // zeros: no effect
        expect_rd("R3", 16'h1001, 8'hAA);

        cur_req = "R6";
        step(16'h1000, 1, 8'h30, 0);
        expect_rd("R6", 16'h1000, 8'h00);

        cur_req = "R4";
        step(16'h1000, 1, 8'h0F, 0);              // clear all
        step(16'h1000, 1, 8'h99, 0);              // set+clr on SIG1 and LM0
        expect_rd("R4", 16'h1001, 8'hA9);

        cur_req = "R5";
        step(16'h1000, 1, 8'h03, 2'b11);          // clear LM1/LM0 vs hit
        expect_rd("R5", 16'h1001, 8'hAB);
        step(16'h1000, 1, 8'h0F, 0);
        step(16'h0000, 0, 8'h00, 2'b10);          // hit alone on LM1
        expect_rd("R5", 16'h1001, 8'hA2);

        cur_req = "R7";
        step(16'h1001, 1, 8'hF0, 0);
        step(16'h1000, 1, 8'hC0, 0);
        expect_rd("R7", 16'h1001, 8'hFE);
        step(16'h1001, 1, 8'h50, 0);

        cur_req = "R8";
        step(16'h1002, 1, 8'hFF, 0);
        step(16'h0001, 1, 8'h0F, 0);
        step(16'h1003, 1, 8'hFF, 0);
        expect_rd("R8", 16'h1001, 8'h5E);

        cur_req = "R9";
        expect_rd("R9", 16'h2001, 8'h00);
        step(16'h1001, 1, 8'h30, 0);
        expect_rd("R9", 16'h1001, 8'h3E);

        cur_req = "R7";
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[1] ? 16'h1001 : (lfsr[2] ? 16'h1000 : 16'h1005),
                 lfsr[3], lfsr[15:8], (lfsr[7:4] == 4'h0) ? lfsr[6:5] : 2'b00);
        end

        cur_req = "R1";
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        expect_rd("R1", 16'h1001, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule